// File: doc/BRIEF.md
# Dual Masked Time-of-Day Alarm Unit

This block holds two alarm register sets, alarm 0 and alarm 1. Each set has four byte fields: seconds, minutes, hours and day. Bit 7 of every field is a mask bit. The lower seven bits hold the BCD value to compare. On every clock-update strobe from the timekeeping counter, each set is compared with the live time. A set that matches raises its own request flag.

The two flags drive two active-low, open-drain interrupt lines. A routing input chooses between two arrangements. In the first, each alarm has its own line. In the second, both alarms share line 0. A per-alarm enable gates each flag onto its line.

The register-access logic gives the block a byte address, a strobe and write data. The block loads alarm fields from that port and returns read data for the alarm fields and the status byte. It also clears an alarm's flag whenever an access touches any register of that alarm.

Top module: `tod_alarm_pair`

## Requirements
- R1: While reset is held and right after it is released, both flags read 0 and both output enables `int0_oe` and `int1_oe` are 0. Every alarm field also reads 0x00.
- R2: `acc_addr[6:0]` selects a register. Alarm 0 occupies 0x07 to 0x0A and alarm 1 occupies 0x0B to 0x0E, in the field order seconds, minutes, hours, day. When `acc_stb` is 1 and `acc_addr[7]` is 1, the selected field is loaded with `acc_wdata` at the clock edge. `acc_rdata` shows the selected field combinationally. At 0x10 it shows the status byte {6'b0, flag1, flag0}. Any other index reads 0x00.
- R3: A field matches when its bit 7 is 1 or when its bits [6:0] equal bits [6:0] of the corresponding live-time byte. An alarm matches when all four of its fields match. A flag is set at the edge where `upd` is 1 and its alarm matches. Without `upd`, a flag never rises.
- R4: An access strobe whose index lies in an alarm's own range clears that alarm's flag at the edge, whether it is a read or a write. Indices outside that range, including the other alarm's range and the status byte, leave the flag unchanged.
- R5: A flag stays set until it is cleared. If a set and a clear happen in the same cycle, the flag ends up set.
- R6: With `route_split` at 1, `int0_oe` is `flag0 & irq_en0` and `int1_oe` is `flag1 & irq_en1`. The flags themselves are set regardless of the enables.
- R7: With `route_split` at 0, `int0_oe` is `(flag0 & irq_en0) | (flag1 & irq_en1)` and `int1_oe` stays 0.
- R8: Both interrupt data outputs `int0_do` and `int1_do` are always 0. A line is therefore pulled low exactly when its output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd | input | 1 | Clock-update strobe; triggers comparison |
| time_sec | input | 8 | Live seconds, BCD |
| time_min | input | 8 | Live minutes, BCD |
| time_hour | input | 8 | Live hours, same 12/24-hour encoding as the alarm hours field |
| time_day | input | 8 | Live day of week |
| acc_stb | input | 1 | Register access strobe |
| acc_addr | input | 8 | Bit 7 is the write flag; bits [6:0] are the register index |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the selected index |
| route_split | input | 1 | 1 gives each alarm its own line; 0 makes both alarms share line 0 |
| irq_en0 | input | 1 | Alarm 0 interrupt enable |
| irq_en1 | input | 1 | Alarm 1 interrupt enable |
| flags | output | 2 | Request flags {flag1, flag0} |
| int0_oe | output | 1 | Line 0 pull-down enable |
| int0_do | output | 1 | Line 0 data, always 0 |
| int1_oe | output | 1 | Line 1 pull-down enable |
| int1_do | output | 1 | Line 1 data, always 0 |

## Verification
The assertions check, on every cycle, the rules that need no knowledge of field values:
- a flag never rises without an update strobe;
- an access to an alarm's own range without an update strobe leaves its flag clear;
- an untouched flag holds;
- the interrupt lines follow the routing and enables, line 1 stays silent in shared mode, and the data outputs stay at 0.

Only the bench scenarios can show that mask patterns and field values produce the right matches. They also show read-back of each register, and that set wins over clear in a collision.

// File: rtl/tod_alarm_pair.sv
module tod_alarm_pair #(
  parameter int          DW      = 8,
  parameter int          AW      = 7,
  parameter int          NALM    = 2,
  parameter int          NFLD    = 4,
  parameter logic [6:0]  BASE    = 7'h07,
  parameter logic [6:0]  STATIDX = 7'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  logic [7:0]  time_sec,
  input  logic [7:0]  time_min,
  input  logic [7:0]  time_hour,
  input  logic [7:0]  time_day,
  input  logic        acc_stb,
  input  logic [7:0]  acc_addr,
  input  logic [7:0]  acc_wdata,
  output logic [7:0]  acc_rdata,
  input  logic        route_split,
  input  logic        irq_en0,
  input  logic        irq_en1,
  output logic [1:0]  flags,
  output logic        int0_oe,
  output logic        int0_do,
  output logic        int1_oe,
  output logic        int1_do
);
  localparam int FSW = $clog2(NFLD);

  logic [DW-1:0]   alm [NALM][NFLD];
  logic [DW-1:0]   now [NFLD];
  logic [NALM-1:0] flag;
  logic [NALM-1:0] hit;
  logic [NALM-1:0] fire;
  logic [FSW-1:0]  fsel [NALM];

  wire [AW-1:0] idx = acc_addr[AW-1:0];
  wire          wr  = acc_addr[AW];

  assign now[0] = time_sec;
  assign now[1] = time_min;
  assign now[2] = time_hour;
  assign now[3] = time_day;

  for (genvar k = 0; k < NALM; k++) begin : g_set
    localparam logic [AW-1:0] LO = AW'(int'(BASE) + k*NFLD);
    wire [AW-1:0]   off = idx - LO;
    logic [NFLD-1:0] ok;
    for (genvar f = 0; f < NFLD; f++) begin : g_fld
      assign ok[f] = alm[k][f][DW-1] | (alm[k][f][DW-2:0] == now[f][DW-2:0]);
    end
    assign hit[k]  = acc_stb && (idx >= LO) && (off < AW'(NFLD));
    assign fsel[k] = off[FSW-1:0];
    assign fire[k] = upd && (&ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NALM; k++)
        for (int f = 0; f < NFLD; f++)
          alm[k][f] <= '0;
      flag <= '0;
    end else begin
      for (int k = 0; k < NALM; k++) begin
        if (hit[k] && wr) alm[k][fsel[k]] <= acc_wdata;
        flag[k] <= fire[k] | (flag[k] & ~hit[k]);
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    for (int k = 0; k < NALM; k++)
      for (int f = 0; f < NFLD; f++)
        if (idx == AW'(int'(BASE) + k*NFLD + f)) acc_rdata = alm[k][f];
    if (idx == STATIDX) acc_rdata = {{(DW-NALM){1'b0}}, flag};
  end

  assign flags   = flag;
  assign int0_oe = (flag[0] & irq_en0) | (~route_split & flag[1] & irq_en1);
  assign int1_oe = route_split & flag[1] & irq_en1;
  assign int0_do = 1'b0;
  assign int1_do = 1'b0;
endmodule

module tod_alarm_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd,
  input logic       acc_stb,
  input logic [7:0] acc_addr,
  input logic       route_split,
  input logic       irq_en0,
  input logic       irq_en1,
  input logic [1:0] flags,
  input logic       int0_oe,
  input logic       int0_do,
  input logic       int1_oe,
  input logic       int1_do
);
  wire touch0 = acc_stb && acc_addr[6:0] >= 7'h07 && acc_addr[6:0] <= 7'h0A;
  wire touch1 = acc_stb && acc_addr[6:0] >= 7'h0B && acc_addr[6:0] <= 7'h0E;

  always_comb begin
    if (rst_n) assert_od_zero_R8: assert (int0_do == 1'b0 && int1_do == 1'b0);
  end

  assert_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> (!$rose(flags[0]) && !$rose(flags[1])));
  assert_clear0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (touch0 && !upd) |=> !flags[0]);
  assert_clear1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (touch1 && !upd) |=> !flags[1]);
  assert_hold0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !touch0) |=> flags[0]);
  assert_hold1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !touch1) |=> flags[1]);
  assert_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (route_split && flags[1] && irq_en1) |-> (int1_oe && !(int0_oe && !(flags[0] && irq_en0))));
  assert_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !route_split |-> !int1_oe);
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 2'b00) |-> (!int0_oe && !int1_oe));
endmodule

bind tod_alarm_pair tod_alarm_pair_chk u_chk (.*);

// File: tb/tod_alarm_pair_test.sv
module tod_alarm_pair_test;
  logic clk = 0, rst_n = 0;
  logic upd = 0, acc_stb = 0;
  logic [7:0] time_sec = 0, time_min = 0, time_hour = 0, time_day = 0;
  logic [7:0] acc_addr = 0, acc_wdata = 0, acc_rdata;
  logic route_split = 1, irq_en0 = 1, irq_en1 = 1;
  logic [1:0] flags;
  logic int0_oe, int0_do, int1_oe, int1_do;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] m_alm [2][4];
  logic [1:0] m_flag;

  always #10 clk = ~clk;

  tod_alarm_pair uut (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [6:0] i);
    if (i >= 7'h07 && i <= 7'h0E) return m_alm[(i - 7'h07) / 4][(i - 7'h07) % 4];
    if (i == 7'h10) return {6'b0, m_flag};
    return 8'h00;
  endfunction

  function automatic bit m_match(int k, logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] d);
    logic [7:0] t [4];
    t[0] = s; t[1] = mi; t[2] = h; t[3] = d;
    for (int f = 0; f < 4; f++)
      if (!m_alm[k][f][7] && m_alm[k][f][6:0] != t[f][6:0]) return 0;
    return 1;
  endfunction

  task automatic check_out(string tag);
    logic e0, e1;
    e0 = (m_flag[0] & irq_en0) | (~route_split & m_flag[1] & irq_en1);
    e1 = route_split & m_flag[1] & irq_en1;
    chk(tag, "flags", flags, m_flag);
    chk(tag, "int0_oe", int0_oe, e0);
    chk(tag, "int1_oe", int1_oe, e1);
    chk("R8", "int_do", {int0_do, int1_do}, 0);
  endtask

  task automatic step(string tag, bit u, logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                      logic [7:0] d, bit stb, logic [7:0] a, logic [7:0] w);
    logic [1:0] setv, clrv;
    @(negedge clk);
    upd = u; time_sec = s; time_min = mi; time_hour = h; time_day = d;
    acc_stb = stb; acc_addr = a; acc_wdata = w;
    #2;
    chk(tag, "rdata", acc_rdata, exp_rd(a[6:0]));
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      setv[k] = u && m_match(k, s, mi, h, d);
      clrv[k] = stb && a[6:0] >= 7'(7 + 4*k) && a[6:0] <= 7'(10 + 4*k);
    end
    if (stb && a[7] && a[6:0] >= 7'h07 && a[6:0] <= 7'h0E)
      m_alm[(a[6:0] - 7'h07) / 4][(a[6:0] - 7'h07) % 4] = w;
    m_flag = setv | (m_flag & ~clrv);
    #5;
    check_out(tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] tv [4];
    for (int k = 0; k < 2; k++) for (int f = 0; f < 4; f++) m_alm[k][f] = 0;
    m_flag = 0;
    #35;
    chk("R1", "flags in reset", flags, 0);
    chk("R1", "oe in reset", {int0_oe, int1_oe}, 0);
    @(negedge clk); rst_n = 1;
    acc_addr = 8'h07; #2;
    chk("R1", "alarm field after reset", acc_rdata, 0);
    check_out("R1");

    step("R2", 0, 0, 0, 0, 0, 1, 8'h87, 8'h30);
    step("R2", 0, 0, 0, 0, 0, 1, 8'h88, 8'h45);
    step("R2", 0, 0, 0, 0, 0, 1, 8'h89, 8'h52);
    step("R2", 0, 0, 0, 0, 0, 1, 8'h8A, 8'h03);
    step("R2", 0, 0, 0, 0, 0, 1, 8'h07, 0);
    step("R2", 0, 0, 0, 0, 0, 1, 8'h09, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 8'h11, 0);
    step("R3", 1, 8'h30, 8'h45, 8'h52, 8'h04, 0, 0, 0);
    step("R3", 0, 8'h30, 8'h45, 8'h52, 8'h03, 0, 0, 0);
    step("R3", 1, 8'h30, 8'h45, 8'h52, 8'h03, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 1, 8'h10, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 8'h0B, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 8'h09, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 8'h8A, 8'h83);
    step("R3", 1, 8'h30, 8'h45, 8'h52, 8'h06, 0, 0, 0);
    irq_en0 = 0;
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0);
    irq_en0 = 1;
    step("R5", 1, 8'h30, 8'h45, 8'h52, 8'h01, 1, 8'h07, 0);
    step("R5", 1, 8'h30, 8'h45, 8'h52, 8'h01, 0, 0, 0);
    for (int f = 0; f < 4; f++) step("R2", 0, 0, 0, 0, 0, 1, 8'(8'h8B + f), 8'h80);
    step("R4", 0, 0, 0, 0, 0, 1, 8'h07, 0);
    step("R6", 1, 8'h11, 8'h22, 8'h33, 8'h04, 0, 0, 0);
    route_split = 0;
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0);
    irq_en1 = 0;
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0);
    irq_en1 = 1;
    step("R4", 0, 0, 0, 0, 0, 1, 8'h0E, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0);

    void'($urandom(32'h5eed1305));
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] a, w;
      bit u, s;
      if ($urandom % 16 == 0) begin
        route_split = $urandom % 2; irq_en0 = $urandom % 2; irq_en1 = $urandom % 2;
      end
      for (int f = 0; f < 4; f++) tv[f] = 8'($urandom % 2);
      u = ($urandom % 2) == 1;
      s = ($urandom % 3) == 0;
      a = {1'($urandom % 2), 7'(5 + $urandom % 13)};
      w = {1'($urandom % 4 == 0), 7'($urandom % 2)};
      step(route_split ? "R3" : "R7", u, tv[0], tv[1], tv[2], tv[3], s, a, w);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule